// File: doc/BRIEF.md
# Scanline Interrupt and Multiplier Register Block

This block is a small register file on the CPU side of a cartridge bank-switching controller. It watches the scanline count from the video side and raises an interrupt request when a programmed target line is reached. A status byte shows that a target line was hit and that the scanline count has gone past the last visible line. The same register window also has an unsigned 8x8 multiplier: software writes the two factors and reads the 16-bit product back as two bytes.

The CPU side is a plain byte bus with single-cycle read and write strobes. There is no valid/ready handshake anywhere, because the block can never hold off a transfer. A write takes effect on the clock edge where `bus_wr` is high. A read is served on the edge where `bus_rd` is high, and the data stays on `bus_rdata` until the next read. The video side gives the current line number together with a one-cycle strobe once per line. The interrupt output is a level. It stays high until software reads the status byte.

The target-line register is written in two ways. While it holds a small value (below 0x40), a write adds the written byte to it, so software can step it forward relative to the current value. Once it holds 0x40 or more, a write replaces it. A target of 0x40 or more fires only once: its match turns the enable byte off.

Top module: `scanline_irq_mul`

## Requirements
- R1: After reset, `irq` is low. The status byte, the enable byte, the target line and both multiplier factors are all zero. A status read therefore returns 0x00, and a product read returns 0x00.
- R2: Read data is registered. It appears on `bus_rdata` in the cycle after the `bus_rd` edge and holds until the next read. A read of any address other than 0x5204, 0x5205 and 0x5206 returns the upper byte of the address.
- R3: A read at 0x5204 returns the status byte as it was before the edge, and clears it on that same edge. A flag set by a line strobe in the same cycle survives the clear.
- R4: Status bit 7 (match) is set on a line strobe whose line number is 240 or less and equals the target line.
- R5: Status bit 6 (past visible area) is set on any line strobe whose line number is greater than 240.
- R6: A match sets `irq` only when the enable byte is nonzero and the target line is below 0xF0. Once set, `irq` stays high until a status read (0x5204) or reset. A set in the same cycle as a status read wins.
- R7: A match with a target line of 0x40 or more clears the enable byte, unless the enable byte is written in that same cycle.
- R8: A write at 0x5203 replaces the target line if the target line is currently 0x40 or more. Otherwise the written byte is added to the target line, wrapping modulo 256. A line strobe in the same cycle is compared against the old target.
- R9: Writes at 0x5205 and 0x5206 load factor A and factor B. Reads at 0x5205 and 0x5206 return the low byte and the high byte of the unsigned product A*B.
- R10: A write at 0x5204 loads the enable byte. Any nonzero value enables the interrupt. The write does not change the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| line_num | input | 9 | Current scanline number |
| line_stb | input | 1 | One-cycle strobe, once per scanline |
| irq | output | 1 | Interrupt request, level |

## Verification
The bound checker watches several behaviours on every cycle:
- A status read clears the status byte.
- The two status flags appear after the qualifying strobe.
- A rising `irq` always follows an enabled match below 0xF0, and `irq` holds until it is acknowledged.
- A one-shot match turns the enable off.
- The product bytes come back one cycle after the read.
- The read data holds between reads.

Only the bench scenarios can show the accumulate-or-replace rule of the target register, including its wrap. They also show that a target of 0xF0 matches without interrupting, and that the full-scale product 0xFF*0xFF is correct. The same goes for the priority of a flag set that lands on the same edge as a status read.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int LINE_W = 9;

  // register addresses; software relies on these exact locations
  localparam logic [ADDR_W-1:0] A_TARGET = 16'h5203;
  localparam logic [ADDR_W-1:0] A_STATUS = 16'h5204;
  localparam logic [ADDR_W-1:0] A_MUL_LO = 16'h5205;
  localparam logic [ADDR_W-1:0] A_MUL_HI = 16'h5206;

  // decoded one-cycle access strobes
  typedef struct packed {
    logic wr_target;
    logic wr_enable;
    logic wr_fac_a;
    logic wr_fac_b;
    logic rd_status;
  } scl_dec_t;
endpackage

// File: rtl/scl_target.sv
module scl_target #(
  parameter int DATA_W  = 8,
  parameter int ONESHOT = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] target
);
  localparam logic [DATA_W-1:0] ONESHOT_V = DATA_W'(ONESHOT);

  logic              replace;
  logic [DATA_W-1:0] sum;

  // Small targets accumulate; large ones are overwritten.
  assign replace = (target >= ONESHOT_V);
  assign sum     = target + wdata; // wraps at the register width

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     target <= '0;
    else if (wr)    target <= replace ? wdata : sum;
  end
endmodule

// File: rtl/scl_line_mon.sv
module scl_line_mon #(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 240,
  parameter int ONESHOT   = 8'h40,
  parameter int NOIRQ     = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] target,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_status,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  localparam int MATCH_BIT = DATA_W - 1;
  localparam int PAST_BIT  = DATA_W - 2;
  localparam logic [LINE_W-1:0] LAST_V    = LINE_W'(LAST_LINE);
  localparam logic [DATA_W-1:0] ONESHOT_V = DATA_W'(ONESHOT);
  localparam logic [DATA_W-1:0] NOIRQ_V   = DATA_W'(NOIRQ);

  logic              visible, match, past_vis, fire;
  logic [DATA_W-1:0] set_bits, status_nx;

  assign visible  = (line_num <= LAST_V);
  assign match    = line_stb && visible && (line_num == LINE_W'(target));
  assign past_vis = line_stb && !visible;
  assign fire     = match && (enable != '0) && (target < NOIRQ_V);

  always_comb begin
    set_bits            = '0;
    set_bits[MATCH_BIT] = match;
    set_bits[PAST_BIT]  = past_vis;
    // a read clears; flags raised on the same edge survive
    status_nx = (rd_status ? '0 : status) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      if (wr_enable)                          enable <= wdata;
      else if (match && target >= ONESHOT_V)  enable <= '0;
      if (fire)           irq <= 1'b1;
      else if (rd_status) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_mul.sv
module scl_mul #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          wr_fac,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   fac_a,
  output logic [DATA_W-1:0]   fac_b,
  output logic [2*DATA_W-1:0] product
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] fac_q [2];

  for (genvar i = 0; i < 2; i++) begin : g_fac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fac_q[i] <= '0;
      else if (wr_fac[i]) fac_q[i] <= wdata;
    end
  end

  assign fac_a   = fac_q[0];
  assign fac_b   = fac_q[1];
  assign product = PROD_W'(fac_a) * PROD_W'(fac_b);
endmodule

// File: rtl/scanline_irq_mul.sv
module scanline_irq_mul
  import scl_pkg::*;
#(
  parameter int LAST_LINE = 240,
  parameter int ONESHOT   = 8'h40,
  parameter int NOIRQ     = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_stb,
  output logic              irq
);
  localparam int PROD_W = 2 * DATA_W;

  scl_dec_t          dec;
  logic [DATA_W-1:0] target_q, status_q, enable_q, fac_a, fac_b;
  logic [PROD_W-1:0] product;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    dec           = '0;
    dec.wr_target = bus_wr && (bus_addr == A_TARGET);
    dec.wr_enable = bus_wr && (bus_addr == A_STATUS);
    dec.wr_fac_a  = bus_wr && (bus_addr == A_MUL_LO);
    dec.wr_fac_b  = bus_wr && (bus_addr == A_MUL_HI);
    dec.rd_status = bus_rd && (bus_addr == A_STATUS);
  end

  scl_target #(.DATA_W(DATA_W), .ONESHOT(ONESHOT)) u_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (dec.wr_target),
    .wdata  (bus_wdata),
    .target (target_q)
  );

  scl_line_mon #(
    .DATA_W(DATA_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE),
    .ONESHOT(ONESHOT), .NOIRQ(NOIRQ)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .target    (target_q),
    .wr_enable (dec.wr_enable),
    .wdata     (bus_wdata),
    .rd_status (dec.rd_status),
    .line_stb  (line_stb),
    .line_num  (line_num),
    .status    (status_q),
    .enable    (enable_q),
    .irq       (irq)
  );

  scl_mul #(.DATA_W(DATA_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fac  ({dec.wr_fac_b, dec.wr_fac_a}),
    .wdata   (bus_wdata),
    .fac_a   (fac_a),
    .fac_b   (fac_b),
    .product (product)
  );

  always_comb begin
    unique case (bus_addr)
      A_STATUS: rd_mux = status_q;
      A_MUL_LO: rd_mux = product[DATA_W-1:0];
      A_MUL_HI: rd_mux = product[PROD_W-1:DATA_W];
      default:  rd_mux = bus_addr[ADDR_W-1 -: DATA_W];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/scl_checker.sv
module scl_checker
  import scl_pkg::*;
#(
  parameter int LAST_LINE = 240,
  parameter int ONESHOT   = 8'h40,
  parameter int NOIRQ     = 8'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LINE_W-1:0] line_num,
  input logic              line_stb,
  input logic              irq,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] enable_q,
  input logic [DATA_W-1:0] target_q,
  input logic [DATA_W-1:0] fac_a,
  input logic [DATA_W-1:0] fac_b
);
  logic [2*DATA_W-1:0] prod_ref;
  logic rd_stat, hit;
  assign prod_ref = (2*DATA_W)'(fac_a) * (2*DATA_W)'(fac_b);
  assign rd_stat  = bus_rd && (bus_addr == A_STATUS);
  assign hit      = line_stb && (line_num <= LINE_W'(LAST_LINE))
                    && (line_num == LINE_W'(target_q));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  assert_status_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !line_stb |=> status_q == '0);
  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q[DATA_W-1]);
  assert_past_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && line_num > LINE_W'(LAST_LINE) |=> status_q[DATA_W-2]);
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit && enable_q != '0 && target_q < DATA_W'(NOIRQ)));
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_stat |=> irq);
  assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && target_q >= DATA_W'(ONESHOT) && !(bus_wr && bus_addr == A_STATUS)
    |=> enable_q == '0);
  assert_prod_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_MUL_LO |=> bus_rdata == $past(prod_ref[DATA_W-1:0]));
endmodule

bind scanline_irq_mul scl_checker #(
  .LAST_LINE(LAST_LINE), .ONESHOT(ONESHOT), .NOIRQ(NOIRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .line_num(line_num),
  .line_stb(line_stb), .irq(irq), .status_q(status_q),
  .enable_q(enable_q), .target_q(target_q), .fac_a(fac_a), .fac_b(fac_b)
);

// File: tb/scanline_irq_mul_bench.sv
module scanline_irq_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [8:0]  line_num = '0;
  logic        line_stb = 1'b0;
  logic        irq;

  int checks = 0, fails = 0;

  // reference state kept by the bench
  logic [7:0] m_status = 0, m_en = 0, m_target = 0, m_a = 0, m_b = 0;
  logic       m_irq = 0;

  always #4 clk = ~clk;

  scanline_irq_mul u_scanline_irq_mul (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .line_num(line_num), .line_stb(line_stb), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    logic [15:0] p;
    p = 16'(m_a) * 16'(m_b);
    case (a)
      16'h5204: return m_status;
      16'h5205: return p[7:0];
      16'h5206: return p[15:8];
      default:  return a[15:8];
    endcase
  endfunction

  // one bus/line cycle; model advances on the same edge as the design
  task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                      input logic [7:0] d, input logic stb, input logic [8:0] ln,
                      input string req);
    logic [7:0] exp_rd;
    logic match, fire, rds;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    line_stb = stb; line_num = ln;
    exp_rd = rd_ref(a);
    rds   = rd && a == 16'h5204;
    match = stb && ln <= 240 && ln == {1'b0, m_target};
    fire  = match && m_en != 0 && m_target < 8'hF0;
    m_status = (rds ? 8'h00 : m_status) | {match, stb && ln > 240, 6'b0};
    if (fire) m_irq = 1'b1; else if (rds) m_irq = 1'b0;
    if (wr && a == 16'h5204) m_en = d;
    else if (match && m_target >= 8'h40) m_en = 8'h00;
    if (wr && a == 16'h5203) m_target = (m_target >= 8'h40) ? d : m_target + d;
    if (wr && a == 16'h5205) m_a = d;
    if (wr && a == 16'h5206) m_b = d;
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0; line_stb = 0;
    if (rd) check(req, {8'h00, bus_rdata}, {8'h00, exp_rd});
    check({req, "/R6 irq"}, {15'h0, irq}, {15'h0, m_irq});
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d, input string req);
    step(0, 1, a, d, 0, 0, req);
  endtask
  task automatic rd_reg(input logic [15:0] a, input string req);
    step(1, 0, a, 0, 0, 0, req);
  endtask
  task automatic line(input logic [8:0] ln, input string req);
    step(0, 0, 0, 0, 1, ln, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1357);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {15'h0, irq}, 16'h0);
    rd_reg(16'h5204, "R1 status");
    rd_reg(16'h5206, "R1 product");
    // R2 unmapped read
    rd_reg(16'h5203, "R2 unmapped");
    rd_reg(16'hA1B2, "R2 unmapped");
    // R8 accumulate then R4 match without enable
    wr_reg(16'h5203, 8'h10, "R8");
    wr_reg(16'h5203, 8'h20, "R8");
    line(9'h030, "R4");
    rd_reg(16'h5204, "R4 match flag");
    rd_reg(16'h5204, "R3 cleared");
    // R10 enable write leaves status alone; R6 irq
    line(9'd250, "R5");
    wr_reg(16'h5204, 8'h01, "R10");
    rd_reg(16'h5204, "R5 R10 status");
    line(9'h030, "R6 fire");
    line(9'h031, "R6 hold");
    // R3 set on same edge as clear survives
    step(1, 0, 16'h5204, 0, 1, 9'd260, "R3 same edge");
    rd_reg(16'h5204, "R3 survivor");
    // R8 wrap: 0x30 + 0xE0 = 0x10
    wr_reg(16'h5203, 8'hE0, "R8 wrap");
    line(9'h010, "R8 wrap match");
    rd_reg(16'h5204, "R8 R3 ack");
    // R8 replace: 0x10+0x50=0x60, then replace with 0x70
    wr_reg(16'h5203, 8'h50, "R8");
    wr_reg(16'h5203, 8'h70, "R8 replace");
    line(9'h070, "R7 one-shot fire");
    rd_reg(16'h5204, "R7 ack");
    line(9'h070, "R7 disabled no irq");
    // R6 boundary target 0xF0
    wr_reg(16'h5203, 8'hF0, "R8");
    wr_reg(16'h5204, 8'h80, "R10");
    line(9'd240, "R6 no irq at F0");
    rd_reg(16'h5204, "R4 flag at 240");
    // R9 multiplier
    wr_reg(16'h5205, 8'hFF, "R9");
    wr_reg(16'h5206, 8'hFF, "R9");
    rd_reg(16'h5205, "R9 lo");
    rd_reg(16'h5206, "R9 hi");
    wr_reg(16'h5205, 8'h0C, "R9");
    rd_reg(16'h5206, "R9 hi");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 7);
      case (k)
        0: wr_reg(16'h5203, 8'($urandom_range(0, 90)), "R8 rnd");
        1: wr_reg(16'h5204, ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom), "R10 rnd");
        2: wr_reg(16'h5205, 8'($urandom), "R9 rnd");
        3: wr_reg(16'h5206, 8'($urandom), "R9 rnd");
        4: rd_reg(16'h5205 + 16'($urandom_range(0, 1)), "R9 rnd");
        5: rd_reg(16'h5204, "R3 rnd");
        6: begin
          logic [8:0] ln;
          ln = ($urandom_range(0, 2) == 0) ? 9'($urandom_range(0, 261))
                                           : {1'b0, m_target};
          step($urandom_range(0, 3) == 0, 0, 16'h5204, 0, 1, ln, "R4 R5 rnd");
        end
        default: rd_reg(16'($urandom), "R2 rnd");
      endcase
    end
    finish_run();
  end
endmodule